// File: doc/BRIEF.md
# SECDED-Protected Dual-Port Memory

This block is a 512-word by 64-bit memory with an independent write port and read port. Every stored word carries eight check bits from an extended Hamming (72,64) code. The write side computes the check bits from the incoming data and stores them with the word. The current encoder result is also driven on a dedicated output at all times. The read side recomputes the syndrome from the stored word and places the result in a single read register. A single flipped bit is corrected there, while the array itself is left untouched. A double flip is reported and the word is passed through unchanged.

Two bypass modes are selected with the `mode` input:
- `2'b00` (normal) and `2'b11` behave the same way.
- `2'b01` (encode-only) returns the raw stored word and its stored check bits, with no decoding.
- `2'b10` (decode-only) stores the check bits supplied on `wr_check_in` instead of the generated ones.

A 72-bit fault-injection mask flips chosen bits of the codeword as it is written. The synchronous-clear input is present for pin compatibility only and has no effect.

The read side is built around a small status state machine:
- **States:** `RS_IDLE` (after reset, no read yet), `RS_CLEAN`, `RS_SINGLE`, `RS_DOUBLE` and `RS_RAW` (last read was made in encode-only mode).
- **Reset:** reset forces `RS_IDLE`.
- **Read-enabled edge:** on every read-enabled clock edge, the machine moves from any state to the class of the word being read:
  - encode-only mode gives `RS_RAW`;
  - otherwise, a double error gives `RS_DOUBLE`, a single error gives `RS_SINGLE`, and no error gives `RS_CLEAN`.
- **Read enable low:** the machine holds its state.

The two flags and the check-bit output are decoded from this state.

Top module: `ecc_dual_port_ram`

## Requirements
- R1: While `rst_n` is low, and until the first read-enabled edge after it, `rd_data`, `rd_check_out`, `err_single` and `err_double` are all zero.
- R2: A word is written only on a write-clock edge with `wr_en` = 1. Read outputs update only on a read-clock edge with `rd_en` = 1, and hold their values while `rd_en` is low.
- R3: `enc_check_out` is a combinational function of `wr_data`, computed as follows:
  - Data bit i sits at the i-th code position in 1..71 that is not a power of two (3, 5, 6, 7, 9, ...).
  - Check bit j (0..6) is the XOR of the data bits whose position has bit j set.
  - Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R4: After a read-enabled edge with an error-free stored word, `rd_data` equals the written data one cycle later, with both flags low.
- R5: A single flipped data bit is corrected on `rd_data`, with `err_single` = 1 and `err_double` = 0. The stored word keeps the error, so a repeated read reports it again.
- R6: A single flipped check bit, including the overall-parity bit 7, raises `err_single` and leaves `rd_data` equal to the stored data.
- R7: Two flipped bits anywhere in the codeword raise `err_double` with `err_single` = 0, and `rd_data` is the stored word uncorrected. The two flags are never high together.
- R8: In decode-only mode (`mode` = 2'b10), `wr_check_in` is stored as the check bits in place of the generated ones, and reads decode against it.
- R9: In encode-only mode (`mode` = 2'b01), a read returns the raw stored data on `rd_data` and the stored check bits on `rd_check_out`, with both flags low. In the other modes `rd_check_out` is zero.
- R10: `sync_clear` has no effect on writes, reads or flags.
- R11: `inject_mask` is XORed into the stored codeword `{check[7:0], data[63:0]}` on a write, so mask bit k < 64 flips data bit k and mask bit 64+j flips check bit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the read stage |
| wr_clk | input | 1 | Write-port clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_check_in | input | 8 | External check bits used in decode-only mode |
| enc_check_out | output | 8 | Encoder result for `wr_data` |
| inject_mask | input | 72 | Fault-injection XOR mask on the written codeword |
| rd_clk | input | 1 | Read-port clock |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 9 | Read address |
| rd_data | output | 64 | Registered (corrected or raw) read data |
| rd_check_out | output | 8 | Stored check bits in encode-only mode, else zero |
| err_single | output | 1 | Last read had a single-bit error |
| err_double | output | 1 | Last read had a double-bit error |
| mode | input | 2 | 00/11 normal, 01 encode-only, 10 decode-only |
| sync_clear | input | 1 | Unused synchronous clear, tie low |

## Verification
The assertions check the following on every cycle:
- the two error flags are never high together;
- the read outputs stay stable across any cycle without read enable;
- encode-only reads never raise a flag, and other reads never drive `rd_check_out`;
- an enabled write really lands at its address.

Only the bench scenarios can show the rest:
- the exact check-bit equations;
- that one flipped data bit is put back while one flipped check bit leaves the data alone;
- that a double flip passes through uncorrected;
- that the array keeps the error across repeated reads;
- that external check bits are stored in decode-only mode.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    parameter int DATA_W = 64;
    parameter int HAM_W  = 7;
    parameter int CHK_W  = HAM_W + 1;
    parameter int CODE_W = DATA_W + CHK_W;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_ENC_ONLY = 2'b01,
        MODE_DEC_ONLY = 2'b10,
        MODE_SPARE    = 2'b11
    } ecc_mode_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_CLEAN,
        RS_SINGLE,
        RS_DOUBLE,
        RS_RAW
    } rd_state_e;

    // Code position (1-based) of data bit idx: idx-th non power-of-two position.
    function automatic int data_pos(input int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < (1 << HAM_W); p++) begin
            if (((p & (p - 1)) != 0) && (res == 0)) begin
                if (cnt == idx) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bits that feed Hamming check bit j.
    function automatic logic [DATA_W-1:0] cover_mask(input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = ((data_pos(i) >> j) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [HAM_W-1:0] ham;

    for (genvar j = 0; j < HAM_W; j++) begin : g_ham
        localparam logic [DATA_W-1:0] COVER = cover_mask(j);
        assign ham[j] = ^(data_i & COVER);
    end

    // Overall parity over data and Hamming bits makes the whole codeword even.
    assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
    import ecc_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    logic [CHK_W-1:0] recomputed;
    logic [HAM_W-1:0] syndrome;
    logic             odd_parity;
    logic             unused_recalc_top;

    ecc_encoder u_recalc (
        .data_i (data_i),
        .chk_o  (recomputed)
    );

    assign unused_recalc_top = recomputed[CHK_W-1];
    assign syndrome   = chk_i[HAM_W-1:0] ^ recomputed[HAM_W-1:0];
    assign odd_parity = ^{chk_i, data_i};

    // Odd parity: one flip (syndrome zero means the parity bit itself).
    // Even parity with nonzero syndrome: two flips, left alone.
    assign single_o = odd_parity;
    assign double_o = !odd_parity && (syndrome != '0);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(i));
        assign data_o[i] = data_i[i] ^ (odd_parity && (syndrome == POS));
    end

endmodule

// File: rtl/ecc_storage.sv
module ecc_storage #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 72
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    assign rd_word = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_word)); // R2

endmodule

// File: rtl/ecc_dual_port_ram.sv
module ecc_dual_port_ram
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_check_in,
    output logic [7:0]        enc_check_out,
    input  logic [71:0]       inject_mask,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic [7:0]        rd_check_out,
    output logic              err_single,
    output logic              err_double,
    input  logic [1:0]        mode,
    input  logic              sync_clear
);

    ecc_mode_e         mode_e;
    logic [CHK_W-1:0]  gen_chk;
    logic [CHK_W-1:0]  store_chk;
    logic [CODE_W-1:0] store_word;
    logic [CODE_W-1:0] fetch_word;
    logic [DATA_W-1:0] fixed_data;
    logic              dec_single;
    logic              dec_double;
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] data_q;
    logic [CHK_W-1:0]  chk_q;
    logic              unused_clear;

    assign mode_e       = ecc_mode_e'(mode);
    assign unused_clear = sync_clear;

    // ---------------- write side ----------------
    ecc_encoder u_wr_enc (
        .data_i (wr_data),
        .chk_o  (gen_chk)
    );

    assign enc_check_out = gen_chk;
    assign store_chk     = (mode_e == MODE_DEC_ONLY) ? wr_check_in : gen_chk;
    assign store_word    = {store_chk, wr_data} ^ inject_mask;

    ecc_storage #(
        .ADDR_W (ADDR_W),
        .WORD_W (CODE_W)
    ) u_array (
        .rst_n   (rst_n),
        .wr_clk  (wr_clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (store_word),
        .rd_addr (rd_addr),
        .rd_word (fetch_word)
    );

    // ---------------- read side ----------------
    ecc_syndrome_decoder u_rd_dec (
        .data_i   (fetch_word[DATA_W-1:0]),
        .chk_i    (fetch_word[CODE_W-1:DATA_W]),
        .data_o   (fixed_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    // Next-state selection: class of the word now being read.
    always_comb begin
        if (mode_e == MODE_ENC_ONLY) begin
            state_d = RS_RAW;
        end else if (dec_double) begin
            state_d = RS_DOUBLE;
        end else if (dec_single) begin
            state_d = RS_SINGLE;
        end else begin
            state_d = RS_CLEAN;
        end
    end

    // State register.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else if (rd_en) begin
            state_q <= state_d;
        end
    end

    // Read data stage.
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            chk_q  <= '0;
        end else if (rd_en) begin
            data_q <= (mode_e == MODE_ENC_ONLY) ? fetch_word[DATA_W-1:0] : fixed_data;
            chk_q  <= fetch_word[CODE_W-1:DATA_W];
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rd_data      = data_q;
        err_single   = 1'b0;
        err_double   = 1'b0;
        rd_check_out = '0;
        unique case (state_q)
            RS_IDLE:   rd_data = '0;
            RS_CLEAN:  ;
            RS_SINGLE: err_single = 1'b1;
            RS_DOUBLE: err_double = 1'b1;
            RS_RAW:    rd_check_out = chk_q;
            default:   rd_data = '0;
        endcase
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(err_single && err_double)); // R7

    AST_HOLD_WITHOUT_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data) && $stable(err_single) && $stable(err_double)
                   && $stable(rd_check_out)); // R2

    AST_BYPASS_NO_FLAGS: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && mode == MODE_ENC_ONLY) |=> !err_single && !err_double); // R9

    AST_CHECK_OUT_QUIET: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_en && mode != MODE_ENC_ONLY) |=> rd_check_out == '0); // R9

endmodule

// File: tb/tb_ecc_dual_port_ram.sv
`timescale 1ns/1ps
module tb_ecc_dual_port_ram;

    typedef struct {
        logic [63:0] data;
        logic        s;
        logic        d;
        logic [7:0]  chk;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_check_in;
    logic [7:0]  enc_check_out;
    logic [71:0] inject_mask;
    logic        rd_en;
    logic [8:0]  rd_addr;
    logic [63:0] rd_data;
    logic [7:0]  rd_check_out;
    logic        err_single;
    logic        err_double;
    logic [1:0]  mode;
    logic        sync_clear;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    ecc_dual_port_ram dut (
        .rst_n         (rst_n),
        .wr_clk        (clk),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_check_in   (wr_check_in),
        .enc_check_out (enc_check_out),
        .inject_mask   (inject_mask),
        .rd_clk        (clk),
        .rd_en         (rd_en),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .rd_check_out  (rd_check_out),
        .err_single    (err_single),
        .err_double    (err_double),
        .mode          (mode),
        .sync_clear    (sync_clear)
    );

    // Reference check bits built from the position rule.
    function automatic logic [7:0] ref_check(input logic [63:0] d);
        logic [127:0] cw;
        logic [7:0]   c;
        int           k;
        cw = '0;
        c  = '0;
        k  = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < 7; j++) begin
            for (int p = 1; p < 72; p++) begin
                if (((p >> j) & 1) != 0) c[j] = c[j] ^ cw[p];
            end
        end
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    function automatic exp_t mk(input logic [63:0] d, input logic s, input logic e,
                                input logic [7:0] c, input string t);
        exp_t r;
        r.data = d; r.s = s; r.d = e; r.chk = c; r.tag = t;
        return r;
    endfunction

    task automatic check(input string req, input logic [73:0] act, input logic [73:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [8:0] a, input logic [63:0] d,
                            input logic [71:0] m, input logic [7:0] ci, input logic en);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; inject_mask = m; wr_check_in = ci;
        @(negedge clk);
        wr_en = 1'b0; inject_mask = '0;
    endtask

    task automatic do_read(input logic [8:0] a, input exp_t e);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        sb.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: a read-enabled edge yields one result, checked at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en === 1'b1) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    check("scoreboard-empty", 74'd1, 74'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, {rd_data, err_single, err_double, rd_check_out},
                          {e.data, e.s, e.d, e.chk});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [63:0] PA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PB = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] PC = 64'hA5A5_5A5A_F00F_0FF0;
    localparam logic [63:0] PD = 64'hDEAD_BEEF_CAFE_F00D;
    localparam logic [63:0] PE = 64'h0000_0001_8000_0000;

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_check_in = '0;
        inject_mask = '0; rd_en = 1'b0; rd_addr = '0; mode = 2'b00; sync_clear = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rd_data, err_single, err_double, rd_check_out}, 74'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {rd_data, err_single, err_double, rd_check_out}, 74'd0);

        // R3: encoder output for several patterns
        begin
            logic [63:0] pats [5];
            pats[0] = PA; pats[1] = PB; pats[2] = PC; pats[3] = 64'd0; pats[4] = PE;
            for (int i = 0; i < 5; i++) begin
                wr_data = pats[i];
                #1;
                check("R3 encoder", {66'd0, enc_check_out}, {66'd0, ref_check(pats[i])});
            end
        end

        // R4: clean writes and reads, address boundaries
        do_write(9'd0,   PA, '0, 8'h00, 1'b1);
        do_write(9'd511, PB, '0, 8'h00, 1'b1);
        do_write(9'd5,   PC, '0, 8'h00, 1'b1);
        do_read(9'd0,   mk(PA, 0, 0, 8'h00, "R4 clean addr 0"));
        do_read(9'd511, mk(PB, 0, 0, 8'h00, "R4 clean addr 511"));

        // R2: disabled write leaves the word; outputs hold without read enable
        do_write(9'd5, PD, '0, 8'h00, 1'b0);
        do_read(9'd5, mk(PC, 0, 0, 8'h00, "R2 write ignored when disabled"));
        drain();
        rd_addr = 9'd0;
        repeat (3) @(negedge clk);
        check("R2 hold while rd_en low", {rd_data, err_single, err_double, rd_check_out},
              {PC, 1'b0, 1'b0, 8'h00});

        // R5 / R11: single data bit flip, corrected, array keeps error
        do_write(9'd10, PD, 72'd1 << 17, 8'h00, 1'b1);
        do_read(9'd10, mk(PD, 1, 0, 8'h00, "R5 single data flip corrected"));
        do_read(9'd10, mk(PD, 1, 0, 8'h00, "R5 repeated read still flags"));
        do_write(9'd15, PA, 72'd1 << 63, 8'h00, 1'b1);
        do_read(9'd15, mk(PA, 1, 0, 8'h00, "R11 mask bit 63 flips data msb"));

        // R6: check-bit flips
        do_write(9'd11, PD, 72'd1 << 64, 8'h00, 1'b1);
        do_read(9'd11, mk(PD, 1, 0, 8'h00, "R6 check bit 0 flip"));
        do_write(9'd12, PD, 72'd1 << 71, 8'h00, 1'b1);
        do_read(9'd12, mk(PD, 1, 0, 8'h00, "R6 overall parity flip"));

        // R7: double flips
        do_write(9'd13, PD, (72'd1 << 3) | (72'd1 << 40), 8'h00, 1'b1);
        do_read(9'd13, mk(PD ^ ((64'd1 << 3) | (64'd1 << 40)), 0, 1, 8'h00,
                          "R7 two data flips"));
        do_write(9'd14, PD, (72'd1 << 2) | (72'd1 << 66), 8'h00, 1'b1);
        do_read(9'd14, mk(PD ^ (64'd1 << 2), 0, 1, 8'h00, "R7 data plus check flip"));
        drain();

        // R9: encode-only returns raw word and stored check bits
        mode = 2'b01;
        do_read(9'd10, mk(PD ^ (64'd1 << 17), 0, 0, ref_check(PD), "R9 raw single"));
        do_read(9'd12, mk(PD, 0, 0, ref_check(PD) ^ 8'h80, "R9 R11 stored parity flip"));
        do_read(9'd0,  mk(PA, 0, 0, ref_check(PA), "R9 clean raw"));
        drain();

        // R8: decode-only stores external check bits
        mode = 2'b10;
        do_write(9'd20, PE, '0, ref_check(PE) ^ 8'h04, 1'b1);
        do_write(9'd21, PE, '0, ref_check(PE),         1'b1);
        do_write(9'd22, PE, '0, ref_check(PE) ^ 8'h03, 1'b1);
        do_read(9'd20, mk(PE, 1, 0, 8'h00, "R8 external check one bit off"));
        do_read(9'd21, mk(PE, 0, 0, 8'h00, "R8 external check correct"));
        do_read(9'd22, mk(PE, 0, 1, 8'h00, "R8 external check two bits off"));
        drain();
        mode = 2'b01;
        do_read(9'd20, mk(PE, 0, 0, ref_check(PE) ^ 8'h04, "R8 external check stored"));
        drain();

        // R10: sync_clear has no effect
        mode = 2'b00;
        sync_clear = 1'b1;
        do_write(9'd30, PC, 72'd1 << 9, 8'h00, 1'b1);
        do_read(9'd30, mk(PC, 1, 0, 8'h00, "R10 clear ignored on read"));
        do_read(9'd511, mk(PB, 0, 0, 8'h00, "R10 clear ignored on array"));
        drain();
        sync_clear = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule